// File: doc/BRIEF.md
# External Bus Ownership Arbiter

This block decides who drives a shared external memory port: the local core or one outside bus master. The outside master raises a request line. The block passes that line through a synchronizer. It returns a grant only at a boundary between core accesses, never in the middle of one. While the port is granted away, any core access is stalled, and a hold flag tells the outside master that the core is waiting for the port. When the request line falls, the grant is withdrawn and the stalled access starts from where it stopped.

The core presents one access at a time. It gives a write flag and a pair flag. The pair flag marks a read that is the first of two reads belonging to the same instruction. The port may not change hands between those two reads. It may change hands between a read and a following write. A configuration input reserves the port for the core, so that no new grant is issued. The grant path keeps working while reset is held, so an outside master can take the port during boot.

Top module: `xbr_arbiter`

## Requirements
- R1: With no core access in flight and no lock, a request raised before rising edge k gives `ext_bg_o` high after edge k+2 and not earlier. This is a two-stage synchronizer plus the grant register.
- R2: A request dropped before edge k gives `ext_bg_o` low after edge k+2. This holds whatever the value of `excl_i`.
- R3: While an access is in flight (`mem_go_o` high) and `mem_done_i` is low, `ext_bg_o` does not rise. If the request is pending when `mem_done_i` is sampled high, `ext_bg_o` is high and `mem_go_o` is low after that same edge.
- R4: After a read (`acc_we_i`=0) issued with `acc_pair_i`=1 completes, no grant is issued until the following access has also completed.
- R5: A write completes without setting the pair lock, even when `acc_pair_i`=1. A read issued with `acc_pair_i`=0 also leaves no lock.
- R6: While `ext_bg_o` is high and `acc_req_i` is high, `core_stall_o` and `gnt_hold_o` are high and `mem_go_o` stays low.
- R7: With a core request pending, `mem_go_o` rises at the edge after the one where `ext_bg_o` falls.
- R8: While `excl_i` is high, `ext_bg_o` never rises. An existing grant is still held until the request drops.
- R9: While `rst` is high, `mem_go_o` is low and no access starts. The grant still follows the synchronized request.
- R10: `ext_bg_o` and `mem_go_o` are never high together.
- R11: When the block is idle with no grant due, `acc_req_i` gives `mem_go_o` high after the next edge. `core_stall_o` is low in the cycle where `mem_done_i` completes the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the core access state |
| ext_br_i | input | 1 | Bus request from the outside master, asynchronous |
| excl_i | input | 1 | Reserve the port for the core; blocks new grants |
| acc_req_i | input | 1 | Core has an external access ready; held until complete |
| acc_we_i | input | 1 | 1 = write access, 0 = read access |
| acc_pair_i | input | 1 | Read is the first of an instruction's two reads |
| mem_done_i | input | 1 | Memory side reports that the current access finishes this cycle |
| mem_go_o | output | 1 | Core access in flight on the port |
| core_stall_o | output | 1 | Core must wait; its access has not completed |
| ext_bg_o | output | 1 | Bus grant to the outside master |
| gnt_hold_o | output | 1 | Core access ready but held off by the current grant |

## Verification
The bench sweeps all four combinations of write flag and pair flag. In each one the request sits pending through a long access, and the bench checks whether the grant lands at completion. A design that locked on writes, or ignored the lock on paired reads, would show a grant in the wrong case. Grant latency is checked edge by edge on both the rising and the falling request. A missing synchronizer stage, or an extra one, moves the grant by a cycle. The bench also covers a grant pending during reset, exclusive mode that is turned on while already granted, and an access cut off by reset. A design that reset the grant path, or dropped a held grant when exclusive mode came on, fails there.

// File: rtl/xbr_pkg.sv
package xbr_pkg;
  localparam int unsigned XBR_SYNC_STAGES = 2;

  typedef struct packed {
    logic req;
    logic we;
    logic pair;
  } core_acc_t;
endpackage

// File: rtl/xbr_sync.sv
module xbr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain = '0;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) chain[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/xbr_track.sv
module xbr_track
  import xbr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  core_acc_t acc_i,
  input  logic      done_i,
  input  logic      gnt_i,
  input  logic      take_i,
  output logic      busy_o,
  output logic      lock_o,
  output logic      pair_o
);
  logic busy_q, lock_q, pair_q;
  logic start;

  assign start = !busy_q && !gnt_i && !take_i && acc_i.req;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      lock_q <= 1'b0;
      pair_q <= 1'b0;
    end else if (busy_q && done_i) begin
      busy_q <= 1'b0;
      lock_q <= pair_q;
    end else if (start) begin
      busy_q <= 1'b1;
      pair_q <= acc_i.pair && !acc_i.we;
    end
  end

  assign busy_o = busy_q;
  assign lock_o = lock_q;
  assign pair_o = pair_q;

  // R11: a started access remains in flight until the memory side completes it
  a_r11_hold_until_done: assert property (@(posedge clk) disable iff (rst)
    busy_q && !done_i |=> busy_q);
  // R9: reset leaves no access in flight
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> !busy_q);
endmodule

// File: rtl/xbr_grant.sv
module xbr_grant (
  input  logic clk,
  input  logic rst,
  input  logic br_i,
  input  logic excl_i,
  input  logic busy_i,
  input  logic done_i,
  input  logic lock_i,
  input  logic pair_i,
  output logic take_o,
  output logic gnt_o
);
  logic gnt_q = 1'b0;
  logic boundary, lock_eff;

  assign boundary = rst || !busy_i || done_i;
  assign lock_eff = !rst && (busy_i ? pair_i : lock_i);
  assign take_o   = br_i && !excl_i && boundary && !lock_eff;

  always_ff @(posedge clk) begin
    if (gnt_q) gnt_q <= br_i;
    else       gnt_q <= take_o;
  end

  assign gnt_o = gnt_q;

  a_r3_no_midaccess_grant: assert property (@(posedge clk) disable iff (rst)
    busy_i && !done_i && !gnt_q |=> !gnt_q);
  a_r4_no_grant_in_pair: assert property (@(posedge clk) disable iff (rst)
    !busy_i && lock_i && !gnt_q |=> !gnt_q);
  a_r8_exclusive_blocks: assert property (@(posedge clk) disable iff (rst)
    excl_i && !gnt_q |=> !gnt_q);
  a_r2_release: assert property (@(posedge clk) disable iff (rst)
    gnt_q && !br_i |=> !gnt_q);
endmodule

// File: rtl/xbr_arbiter.sv
module xbr_arbiter
  import xbr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = XBR_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_br_i,
  input  logic excl_i,
  input  logic acc_req_i,
  input  logic acc_we_i,
  input  logic acc_pair_i,
  input  logic mem_done_i,
  output logic mem_go_o,
  output logic core_stall_o,
  output logic ext_bg_o,
  output logic gnt_hold_o
);
  core_acc_t acc;
  logic br_sync, busy, lock, pair, take, gnt;

  assign acc = '{req: acc_req_i, we: acc_we_i, pair: acc_pair_i};

  xbr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d_i (ext_br_i),
    .q_o (br_sync)
  );

  xbr_grant u_grant (
    .clk    (clk),
    .rst    (rst),
    .br_i   (br_sync),
    .excl_i (excl_i),
    .busy_i (busy),
    .done_i (mem_done_i),
    .lock_i (lock),
    .pair_i (pair),
    .take_o (take),
    .gnt_o  (gnt)
  );

  xbr_track u_track (
    .clk    (clk),
    .rst    (rst),
    .acc_i  (acc),
    .done_i (mem_done_i),
    .gnt_i  (gnt),
    .take_i (take),
    .busy_o (busy),
    .lock_o (lock),
    .pair_o (pair)
  );

  assign mem_go_o     = busy;
  assign ext_bg_o     = gnt;
  assign core_stall_o = acc_req_i && !(busy && mem_done_i);
  assign gnt_hold_o   = acc_req_i && gnt;

  a_r10_exclusive_owner: assert property (@(posedge clk) disable iff (rst)
    !(ext_bg_o && mem_go_o));
  a_r6_hold_means_idle: assert property (@(posedge clk) disable iff (rst)
    gnt_hold_o |-> (core_stall_o && !mem_go_o));
endmodule

// File: tb/xbr_arbiter_tb.sv
module xbr_arbiter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic br = 1'b0, excl = 1'b0, req = 1'b0, we = 1'b0, pair = 1'b0, done = 1'b0;
  logic mem_go, stall, bg, hold;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xbr_arbiter u_dut (
    .clk (clk), .rst (rst), .ext_br_i (br), .excl_i (excl),
    .acc_req_i (req), .acc_we_i (we), .acc_pair_i (pair), .mem_done_i (done),
    .mem_go_o (mem_go), .core_stall_o (stall), .ext_bg_o (bg), .gnt_hold_o (hold)
  );

  task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (!rst) chk(!(bg && mem_go), "R10 bg&mem_go", bg && mem_go, 1'b0);
  endtask

  task automatic exp_bg(input string tag, input logic e);
    chk(bg === e, tag, bg, e);
  endtask

  task automatic exp_go(input string tag, input logic e);
    chk(mem_go === e, tag, mem_go, e);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // reset state, R9
    repeat (3) tick();
    exp_bg("R9 reset bg", 1'b0);
    exp_go("R9 reset mem_go", 1'b0);
    req = 1'b1; tick(); tick();
    exp_go("R9 no start in reset", 1'b0);
    req = 1'b0;
    br = 1'b1; tick(); tick();
    exp_bg("R9 grant latency in reset", 1'b0);
    tick();
    exp_bg("R9 grant during reset", 1'b1);
    br = 1'b0; tick(); tick();
    exp_bg("R2 release latency", 1'b1);
    tick();
    exp_bg("R2 release", 1'b0);
    rst = 1'b0; tick();

    // R1 idle grant latency
    br = 1'b1; tick(); tick();
    exp_bg("R1 not before edge k+2", 1'b0);
    tick();
    exp_bg("R1 grant at edge k+2", 1'b1);

    // R6 stall and hold while granted
    req = 1'b1; we = 1'b0; pair = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(stall === 1'b1, "R6 stall", stall, 1'b1);
      chk(hold === 1'b1, "R6 hold", hold, 1'b1);
      exp_go("R6 no access while granted", 1'b0);
      tick();
    end

    // R7 resume after release
    br = 1'b0; tick(); tick();
    exp_bg("R2 still granted", 1'b1);
    tick();
    exp_bg("R2 released", 1'b0);
    exp_go("R7 not same edge", 1'b0);
    tick();
    exp_go("R7 resume", 1'b1);
    chk(hold === 1'b0, "R6 hold after release", hold, 1'b0);
    done = 1'b1; #1;
    chk(stall === 1'b0, "R11 stall low on done", stall, 1'b0);
    tick();
    done = 1'b0; req = 1'b0;
    exp_go("R11 access ends", 1'b0);

    // R11 plain start
    req = 1'b1; we = 1'b1; tick();
    exp_go("R11 start next edge", 1'b1);
    done = 1'b1; tick();
    done = 1'b0; req = 1'b0; we = 1'b0;
    exp_go("R11 finish", 1'b0);

    // R3 R4 R5 sweep over write and pair flags
    for (int k = 0; k < 4; k++) begin
      logic kw, kp, locks;
      kw = k[0]; kp = k[1]; locks = kp && !kw;
      req = 1'b1; we = kw; pair = kp; tick();
      exp_go("R11 sweep start", 1'b1);
      br = 1'b1;
      for (int i = 0; i < 6; i++) begin
        tick();
        exp_bg("R3 no grant mid access", 1'b0);
      end
      done = 1'b1; tick();
      done = 1'b0; req = 1'b0; we = 1'b0; pair = 1'b0;
      exp_go("R3 access done", 1'b0);
      if (locks) exp_bg("R4 paired read locks", 1'b0);
      else exp_bg("R5 grant at completion", 1'b1);
      if (locks) begin
        tick(); tick();
        exp_bg("R4 lock holds idle", 1'b0);
        req = 1'b1; tick();
        exp_go("R4 second read starts", 1'b1);
        exp_bg("R4 no grant in second read", 1'b0);
        done = 1'b1; tick();
        done = 1'b0; req = 1'b0;
        exp_bg("R4 grant after pair", 1'b1);
      end
      br = 1'b0; tick(); tick(); tick();
      exp_bg("R2 sweep release", 1'b0);
    end

    // R8 exclusive mode
    excl = 1'b1; br = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick();
      exp_bg("R8 exclusive no grant", 1'b0);
    end
    req = 1'b1; tick();
    exp_go("R8 core access proceeds", 1'b1);
    done = 1'b1; tick();
    done = 1'b0; req = 1'b0;
    exp_bg("R8 no grant at boundary", 1'b0);
    excl = 1'b0; tick();
    exp_bg("R8 grant once cleared", 1'b1);
    excl = 1'b1; tick();
    exp_bg("R8 held grant kept", 1'b1);
    br = 1'b0; tick(); tick();
    exp_bg("R2 exclusive release latency", 1'b1);
    tick();
    exp_bg("R2 release under exclusive", 1'b0);
    excl = 1'b0;

    // R9 reset aborts access
    req = 1'b1; tick();
    exp_go("R9 access before reset", 1'b1);
    rst = 1'b1; tick();
    exp_go("R9 reset clears access", 1'b0);
    rst = 1'b0; req = 1'b0; tick();

    finished = 1'b1;
    finish_run();
  end
endmodule